// File: doc/BRIEF.md
# Fixed Time-Slot Memory Bus Sequencer

This block paces a shared memory bus. It divides each major bus cycle into eight equal minor slots and advances one slot on every enabled minor tick. A fixed, irregular table gives each slot an owner and a transfer kind. The processor has one combined slot that can carry an instruction or data transfer. Each of the two compute units has one instruction slot and one data slot. I/O DMA has two data slots. One slot is never assigned.

In each slot the block looks at the pending-request line that belongs to that slot's owner and transfer kind. If the line is high, the block raises that owner's one-hot grant bit and reports the transfer kind. If the line is low, the slot is marked idle and nobody drives the bus. A slot that goes unused is never handed to another requester.

A one-cycle strobe marks the tick that wraps the slot counter from slot 7 back to slot 0. There is no data path through the block, so it has no valid/ready interface. Every pin is a plain level-type control or status signal.

Top module: `tsb_seq`

## Requirements
- R1: After reset, slot_o is 0 and major_o is 0.
- R2: slot_o advances by one only on a clock edge where en_i and tick_i are both high. On every other edge it holds its value.
- R3: A qualifying tick taken in slot 7 moves slot_o to 0. major_o is high for exactly the one cycle after that edge and low at all other times.
- R4: In slot 0, a high proc_req_i grants owner_o bit 0. xfer_o is then 3 (either kind).
- R5: Compute unit 1 is owner_o bit 1 and compute unit 2 is owner_o bit 2. Slot 1 serves cu_ireq_i[0], slot 6 serves cu_dreq_i[0], slot 2 serves cu_dreq_i[1] and slot 5 serves cu_ireq_i[1]. xfer_o is 1 for instruction slots and 2 for data slots.
- R6: Slots 3 and 7 serve dma_req_i with owner_o bit 3 and xfer_o equal to 2.
- R7: Slot 4 never grants, whatever the request inputs. While enabled it always shows idle_o = 1.
- R8: When the slot owner's request line for that slot is low, idle_o is 1, owner_o is 0 and xfer_o is 0.
- R9: While en_i is low, owner_o is 0, xfer_o is 0 and idle_o is 0.
- R10: owner_o never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Sequencer enable |
| tick_i | input | 1 | Minor-slot tick |
| proc_req_i | input | 1 | Processor has a transfer pending |
| cu_ireq_i | input | 2 | Instruction request per compute unit (bit 0 = unit 1) |
| cu_dreq_i | input | 2 | Data request per compute unit (bit 0 = unit 1) |
| dma_req_i | input | 1 | I/O DMA data request |
| slot_o | output | 3 | Current minor slot |
| owner_o | output | 4 | One-hot bus grant: processor, unit 1, unit 2, DMA |
| xfer_o | output | 2 | Transfer kind: 0 none, 1 instruction, 2 data, 3 either |
| idle_o | output | 1 | Enabled slot left empty |
| major_o | output | 1 | Major-cycle wrap strobe |

## Verification
The major-cycle strobe and the processor grant of slot 0 land in the same cycle. The wrapping tick that raises major_o also moves the counter into the processor's slot. The bench provokes this by holding proc_req_i high while it ticks out of slot 7. In the cycle after that edge it expects major_o = 1, slot_o = 0, owner_o bit 0 and xfer_o = 3. One cycle later it expects the strobe to be gone while the grant stays.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  localparam int NUM_SLOTS = 8;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int NUM_OWN   = 4;

  typedef enum logic [1:0] {
    XF_NONE   = 2'd0,
    XF_INSTR  = 2'd1,
    XF_DATA   = 2'd2,
    XF_EITHER = 2'd3
  } xfer_e;

  typedef enum logic [2:0] {
    OWN_PROC = 3'd0,
    OWN_CU1  = 3'd1,
    OWN_CU2  = 3'd2,
    OWN_DMA  = 3'd3,
    OWN_NONE = 3'd4
  } owner_e;

  typedef struct packed {
    owner_e who;
    xfer_e  kind;
  } slot_ent_t;
endpackage

// File: rtl/tsb_slot_ctr.sv
module tsb_slot_ctr #(
  parameter int NSLOT = 8,
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic [SW-1:0] slot_o,
  output logic          wrap_o
);
  localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

  logic at_last;
  assign at_last = (slot_o == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_o <= '0;
      wrap_o <= 1'b0;
    end else begin
      wrap_o <= step_i && at_last;
      if (step_i) slot_o <= at_last ? '0 : slot_o + 1'b1;
    end
  end
endmodule

// File: rtl/tsb_slot_map.sv
module tsb_slot_map
  import tsb_pkg::*;
(
  input  logic [SLOT_W-1:0] slot_i,
  output slot_ent_t         ent_o
);
  // Fixed, irregular ownership table
  always_comb begin
    unique case (slot_i)
      3'd0:    ent_o = '{who: OWN_PROC, kind: XF_EITHER};
      3'd1:    ent_o = '{who: OWN_CU1,  kind: XF_INSTR};
      3'd2:    ent_o = '{who: OWN_CU2,  kind: XF_DATA};
      3'd3:    ent_o = '{who: OWN_DMA,  kind: XF_DATA};
      3'd4:    ent_o = '{who: OWN_NONE, kind: XF_NONE};
      3'd5:    ent_o = '{who: OWN_CU2,  kind: XF_INSTR};
      3'd6:    ent_o = '{who: OWN_CU1,  kind: XF_DATA};
      default: ent_o = '{who: OWN_DMA,  kind: XF_DATA};
    endcase
  end
endmodule

// File: rtl/tsb_grant.sv
module tsb_grant
  import tsb_pkg::*;
(
  input  logic               en_i,
  input  slot_ent_t          ent_i,
  input  logic               proc_req_i,
  input  logic [1:0]         cu_ireq_i,
  input  logic [1:0]         cu_dreq_i,
  input  logic               dma_req_i,
  output logic [NUM_OWN-1:0] owner_o,
  output logic [1:0]         xfer_o,
  output logic               idle_o
);
  logic pend;

  always_comb begin
    unique case (ent_i.who)
      OWN_PROC: pend = proc_req_i;
      OWN_CU1:  pend = (ent_i.kind == XF_INSTR) ? cu_ireq_i[0] : cu_dreq_i[0];
      OWN_CU2:  pend = (ent_i.kind == XF_INSTR) ? cu_ireq_i[1] : cu_dreq_i[1];
      OWN_DMA:  pend = dma_req_i;
      default:  pend = 1'b0;
    endcase
  end

  for (genvar g = 0; g < NUM_OWN; g++) begin : g_own
    assign owner_o[g] = en_i && pend && (ent_i.who == owner_e'(g));
  end

  assign xfer_o = (en_i && pend) ? ent_i.kind : XF_NONE;
  assign idle_o = en_i && !pend;
endmodule

// File: rtl/tsb_seq.sv
module tsb_seq
  import tsb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic               proc_req_i,
  input  logic [1:0]         cu_ireq_i,
  input  logic [1:0]         cu_dreq_i,
  input  logic               dma_req_i,
  output logic [SLOT_W-1:0]  slot_o,
  output logic [NUM_OWN-1:0] owner_o,
  output logic [1:0]         xfer_o,
  output logic               idle_o,
  output logic               major_o
);
  slot_ent_t ent;

  tsb_slot_ctr #(.NSLOT(NUM_SLOTS)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (en_i && tick_i),
    .slot_o (slot_o),
    .wrap_o (major_o)
  );

  tsb_slot_map u_map (
    .slot_i (slot_o),
    .ent_o  (ent)
  );

  tsb_grant u_grant (
    .en_i       (en_i),
    .ent_i      (ent),
    .proc_req_i (proc_req_i),
    .cu_ireq_i  (cu_ireq_i),
    .cu_dreq_i  (cu_dreq_i),
    .dma_req_i  (dma_req_i),
    .owner_o    (owner_o),
    .xfer_o     (xfer_o),
    .idle_o     (idle_o)
  );
endmodule

// File: rtl/tsb_seq_chk.sv
module tsb_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       tick_i,
  input logic [2:0] slot_o,
  input logic [3:0] owner_o,
  input logic [1:0] xfer_o,
  input logic       idle_o,
  input logic       major_o
);
  // R2
  hold_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && tick_i) |=> $stable(slot_o));
  // R3
  wrap_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && slot_o == 3'd7) |=> (slot_o == 3'd0 && major_o));
  // R3
  major_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    major_o |-> slot_o == 3'd0);
  // R4
  proc_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_o[0] |-> (slot_o == 3'd0 && xfer_o == 2'd3));
  // R7
  dead_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o == 3'd4) |-> (owner_o == 4'd0));
  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (owner_o == 4'd0 && xfer_o == 2'd0));
  // R9
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (owner_o == 4'd0 && !idle_o && xfer_o == 2'd0));
  // R10
  owner_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(owner_o));
endmodule

bind tsb_seq tsb_seq_chk chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .tick_i  (tick_i),
  .slot_o  (slot_o),
  .owner_o (owner_o),
  .xfer_o  (xfer_o),
  .idle_o  (idle_o),
  .major_o (major_o)
);

// File: tb/tsb_seq_tb.sv
module tsb_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, tick = 1'b0;
  logic       proc_req = 1'b0, dma_req = 1'b0;
  logic [1:0] cu_ireq = 2'b00, cu_dreq = 2'b00;
  logic [2:0] slot;
  logic [3:0] owner;
  logic [1:0] xfer;
  logic       idle, major;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tsb_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick),
    .proc_req_i(proc_req), .cu_ireq_i(cu_ireq), .cu_dreq_i(cu_dreq),
    .dma_req_i(dma_req), .slot_o(slot), .owner_o(owner), .xfer_o(xfer),
    .idle_o(idle), .major_o(major)
  );

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected owner mask and kind per slot, taken from R4..R7
  function automatic int exp_owner(int s);
    case (s)
      0: return 1; 1: return 2; 2: return 4; 3: return 8;
      4: return 0; 5: return 4; 6: return 2; default: return 8;
    endcase
  endfunction
  function automatic int exp_kind(int s);
    case (s)
      0: return 3; 1: return 1; 5: return 1; 4: return 0;
      default: return 2;
    endcase
  endfunction

  task automatic step();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic goto_slot(int s);
    while (slot != 3'(s)) step();
  endtask

  task automatic t_reset();
    #1;
    check("R1 slot after reset", slot, 0);
    check("R1 major after reset", major, 0);
  endtask

  task automatic t_hold();
    en = 1'b0;
    @(negedge clk); tick = 1'b1;
    repeat (3) @(negedge clk);
    tick = 1'b0;
    check("R2 slot held with enable low", slot, 0);
    en = 1'b1;
    @(negedge clk);
    check("R2 slot held without tick", slot, 0);
    step();
    check("R2 slot advanced on tick", slot, 1);
  endtask

  task automatic t_full_walk();
    proc_req = 1'b1; dma_req = 1'b1; cu_ireq = 2'b11; cu_dreq = 2'b11;
    goto_slot(0);
    for (int s = 0; s < 8; s++) begin
      #1;
      check($sformatf("R4/R5/R6 owner slot %0d", s), owner, exp_owner(s));
      check($sformatf("R4/R5/R6 kind slot %0d", s), xfer, exp_kind(s));
      check($sformatf("R7 idle slot %0d", s), idle, (s == 4) ? 1 : 0);
      step();
    end
  endtask

  task automatic t_single_lines();
    // Only unit 1 instruction pending: only slot 1 grants (R5, R8)
    proc_req = 1'b0; dma_req = 1'b0; cu_ireq = 2'b01; cu_dreq = 2'b00;
    goto_slot(0);
    for (int s = 0; s < 8; s++) begin
      #1;
      check($sformatf("R5 unit1 instr only owner slot %0d", s), owner, (s == 1) ? 2 : 0);
      check($sformatf("R8 unit1 instr only idle slot %0d", s), idle, (s == 1) ? 0 : 1);
      check($sformatf("R8 unit1 instr only kind slot %0d", s), xfer, (s == 1) ? 1 : 0);
      step();
    end
    // Only unit 2 data: slot 2 grants, slot 5 idle (R5)
    cu_ireq = 2'b00; cu_dreq = 2'b10;
    goto_slot(2); #1;
    check("R5 unit2 data slot 2", owner, 4);
    goto_slot(5); #1;
    check("R8 unit2 instr slot 5 empty", idle, 1);
    cu_dreq = 2'b00;
  endtask

  task automatic t_wrap_grant();
    proc_req = 1'b1;
    goto_slot(7);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check("R3 slot wraps to 0", slot, 0);
    check("R3 major strobe", major, 1);
    check("R4 proc grant with strobe", owner, 1);
    check("R4 either kind", xfer, 3);
    @(negedge clk);
    check("R3 major one cycle", major, 0);
    check("R4 grant kept", owner, 1);
  endtask

  task automatic t_disabled();
    proc_req = 1'b1; dma_req = 1'b1; cu_ireq = 2'b11; cu_dreq = 2'b11;
    goto_slot(3);
    en = 1'b0; #1;
    check("R9 owner off while disabled", owner, 0);
    check("R9 idle off while disabled", idle, 0);
    check("R9 kind none while disabled", xfer, 0);
    en = 1'b1;
    goto_slot(4); #1;
    check("R7 slot 4 no owner with all requests", owner, 0);
    check("R7 slot 4 idle", idle, 1);
  endtask

  task automatic t_no_stray_major();
    int seen = 0;
    goto_slot(1);
    for (int k = 0; k < 5; k++) begin
      step();
      seen += major;
    end
    check("R3 no strobe away from wrap", seen, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000 && !done) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 50000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_hold();
    t_full_walk();
    t_single_lines();
    t_wrap_grant();
    t_disabled();
    t_no_stray_major();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule